// File: doc/BRIEF.md
# Run-time selectable CRC accumulator

This block folds a byte stream into a cyclic redundancy check value. It serves three standard generators from one shared datapath: CRC-32 (generator 0x04C11DB7), CRC-32C (generator 0x1EDC6F41) and CRC-16-CCITT (generator 0x1021). The generator is picked at run time by a field of an 8-bit configuration word. Bytes arrive one per clock, qualified by a valid strobe, and each is folded in a single cycle, most significant bit first. The running value can be read continuously on a 32-bit output.

The accumulator starts from all ones for every generator. Input bits are not reflected, the output is not reflected, and no final XOR is applied. Writing the configuration word or pulsing the restart strobe puts the accumulator back to its starting value. The configuration word also holds a compare flag and a 4-bit divider field. Both are stored and read back, but neither changes the arithmetic.

Top module: `crc_mp_top`

## Requirements
- R1: After reset, crc_o reads 0xFFFFFFFF and cfg_o reads 0x00, so the block starts disabled with CRC-32 selected.
- R2: A cycle with cfg_we_i high stores cfg_wdata_i, and cfg_o shows it after that clock edge. The fields are: bit 0 enable, bit 1 compare flag, bits 3:2 generator select, bits 7:4 divider.
- R3: The generator select codes are 0 for CRC-32 (0x04C11DB7), 1 for CRC-32C (0x1EDC6F41) and 2 for CRC-16-CCITT (0x1021). Code 3 behaves exactly like code 0.
- R4: The accumulator starts at all ones and folds bits MSB first, with no reflection and no output XOR. After the nine ASCII bytes "123456789", crc_o reads 0x0376E6E7 with CRC-32 selected and 0x000029B1 with CRC-16-CCITT selected.
- R5: While enabled, each cycle with data_vld_i high folds data_i into the accumulator, and the updated value appears on crc_o after that clock edge. Back-to-back bytes are accepted every cycle.
- R6: While the enable bit is 0, bytes presented with data_vld_i are ignored and crc_o does not change.
- R7: A cycle with cfg_we_i or restart_i high sets the accumulator to all ones at that clock edge. A byte presented in the same cycle is discarded.
- R8: With CRC-16-CCITT selected, only the low 16 bits are used, and crc_o carries them with bits 31:16 reading 0.
- R9: The compare flag and the divider field have no effect on the computed value.
- R10: A cycle with no write, no restart and data_vld_i low leaves crc_o and cfg_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| restart_i | input | 1 | Restart strobe (control register write) |
| data_vld_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| cfg_o | output | 8 | Stored configuration word |
| crc_o | output | 32 | Running CRC value, zero-extended in 16-bit mode |

## Verification
The assertions assume that the strobes and data never carry X or Z after reset. They also assume that no write or byte arrives in the two cycles while the internal reset is still being released. The stimulus meets these assumptions by driving every input to a defined value at each falling edge. It holds all strobes low for several cycles after reset is released. Random traffic then mixes configuration writes, restarts and bytes. Directed sequences cover the nine-byte check string under each select code and with the unused fields set.

// File: rtl/crc_mp_pkg.sv
package crc_mp_pkg;
  localparam int unsigned CRC_W    = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CFG_W    = 8;

  typedef enum logic [1:0] {
    SEL_CRC32  = 2'd0,
    SEL_CRC32C = 2'd1,
    SEL_CRC16  = 2'd2,
    SEL_ALT32  = 2'd3
  } gen_sel_e;

  localparam logic [CRC_W-1:0]    GEN_CRC32  = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0]    GEN_CRC32C = 32'h1EDC_6F41;
  localparam logic [NARROW_W-1:0] GEN_CRC16  = 16'h1021;

  function automatic logic [CRC_W-1:0] wide_gen(gen_sel_e sel);
    return (sel == SEL_CRC32C) ? GEN_CRC32C : GEN_CRC32;
  endfunction
endpackage

// File: rtl/crc_mp_cfg.sv
module crc_mp_cfg
  import crc_mp_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o,
  output logic         enable_o,
  output gen_sel_e     sel_o
);
  logic [W-1:0] cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_d;
  end

  assign cfg_o    = cfg_q;
  assign enable_o = cfg_q[0];
  assign sel_o    = gen_sel_e'(cfg_q[3:2]);
endmodule

// File: rtl/crc_mp_step.sv
module crc_mp_step #(
  parameter int unsigned W    = 32,
  parameter int unsigned BITS = 8
) (
  input  logic [W-1:0]    crc_i,
  input  logic [W-1:0]    gen_i,
  input  logic [BITS-1:0] byte_i,
  output logic [W-1:0]    crc_o
);
  logic [W-1:0] stage [BITS+1];

  assign stage[0] = crc_i;

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    logic fb;
    assign fb         = stage[k][W-1] ^ byte_i[BITS-1-k];
    assign stage[k+1] = {stage[k][W-2:0], 1'b0} ^ (fb ? gen_i : '0);
  end

  assign crc_o = stage[BITS];
endmodule

// File: rtl/crc_mp_top.sv
module crc_mp_top
  import crc_mp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              restart_i,
  input  logic              data_vld_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned HI_W = CRC_W - NARROW_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic     enable;
  gen_sel_e sel;

  crc_mp_cfg #(.W(CFG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .cfg_o    (cfg_o),
    .enable_o (enable),
    .sel_o    (sel)
  );

  logic [CRC_W-1:0]    acc_q, acc_d, wide_nx;
  logic [NARROW_W-1:0] narrow_nx;
  logic                acc_en, narrow;

  assign narrow = (sel == SEL_CRC16);

  crc_mp_step #(.W(CRC_W), .BITS(BYTE_W)) u_wide (
    .crc_i  (acc_q),
    .gen_i  (wide_gen(sel)),
    .byte_i (data_i),
    .crc_o  (wide_nx)
  );

  crc_mp_step #(.W(NARROW_W), .BITS(BYTE_W)) u_narrow (
    .crc_i  (acc_q[NARROW_W-1:0]),
    .gen_i  (GEN_CRC16),
    .byte_i (data_i),
    .crc_o  (narrow_nx)
  );

  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (cfg_we_i || restart_i) begin
      acc_d  = '1;
      acc_en = 1'b1;
    end else if (data_vld_i && enable) begin
      acc_en = 1'b1;
      acc_d  = narrow ? {acc_q[CRC_W-1:NARROW_W], narrow_nx} : wide_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      acc_q <= '1;
    else if (acc_en) acc_q <= acc_d;
  end

  assign crc_o = narrow ? {{HI_W{1'b0}}, acc_q[NARROW_W-1:0]} : acc_q;
endmodule

// File: rtl/crc_mp_chk.sv
module crc_mp_chk
  import crc_mp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic              restart_i,
  input logic              data_vld_i,
  input logic [CFG_W-1:0]  cfg_o,
  input logic [CRC_W-1:0]  crc_o
);
  assert_cfg_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_o == $past(cfg_wdata_i)));

  assert_reinit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i || restart_i) |=>
      (crc_o == ((cfg_o[3:2] == 2'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF)));

  assert_disabled_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_o[0] && !cfg_we_i && !restart_i) |=> $stable(crc_o));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_vld_i && !cfg_we_i && !restart_i) |=> ($stable(crc_o) && $stable(cfg_o)));

  assert_narrow_zero_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o[3:2] == 2'd2) |-> (crc_o[31:16] == 16'h0000));
endmodule

bind crc_mp_top crc_mp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .restart_i   (restart_i),
  .data_vld_i  (data_vld_i),
  .cfg_o       (cfg_o),
  .crc_o       (crc_o)
);

// File: tb/crc_mp_top_tb_top.sv
module crc_mp_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = 8'h00;
  logic        restart_i = 1'b0;
  logic        data_vld_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [7:0]  cfg_o;
  logic [31:0] crc_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] m_acc;
  logic [7:0]  m_cfg;

  always #2.5 clk_i = ~clk_i;

  crc_mp_top dut_i (.*);

  function automatic logic [31:0] ref_fold(logic [31:0] a, logic [7:0] c, logic [7:0] b);
    logic [31:0] r = a;
    for (int i = 7; i >= 0; i--) begin
      if (c[3:2] == 2'd2) begin
        logic fb16 = r[15] ^ b[i];
        r[15:0] = {r[14:0], 1'b0} ^ (fb16 ? 16'h1021 : 16'h0000);
      end else begin
        logic fb32 = r[31] ^ b[i];
        r = {r[30:0], 1'b0} ^ (fb32 ? ((c[3:2] == 2'd1) ? 32'h1EDC6F41 : 32'h04C11DB7) : 32'h0);
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_view(logic [31:0] a, logic [7:0] c);
    return (c[3:2] == 2'd2) ? {16'h0000, a[15:0]} : a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, update model, sample 1 ns after the rising edge
  task automatic cyc(string req, logic we, logic [7:0] wd, logic rs, logic v, logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = we; cfg_wdata_i = wd; restart_i = rs; data_vld_i = v; data_i = d;
    @(posedge clk_i);
    if (we) m_cfg = wd;
    if (we || rs)           m_acc = 32'hFFFF_FFFF;
    else if (v && m_cfg[0]) m_acc = ref_fold(m_acc, m_cfg, d);
    #1;
    check(req, crc_o, ref_view(m_acc, m_cfg));
    check(req, {24'h0, cfg_o}, {24'h0, m_cfg});
  endtask

  task automatic run_string(string req, logic [7:0] c);
    string s = "123456789";
    cyc("R2", 1'b1, c, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 9; i++) cyc(req, 1'b0, 8'h00, 1'b0, 1'b1, s[i]);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_acc = 32'hFFFF_FFFF;
    m_cfg = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    #1;
    check("R1", crc_o, 32'hFFFF_FFFF);
    check("R1", {24'h0, cfg_o}, 32'h0);

    run_string("R4", 8'h01);
    check("R4", crc_o, 32'h0376_E6E7);
    run_string("R3", 8'h05);
    check("R3", crc_o, ref_view(m_acc, 8'h05));
    run_string("R8", 8'h09);
    check("R8", crc_o, 32'h0000_29B1);
    run_string("R3", 8'h0D);
    check("R3", crc_o, 32'h0376_E6E7);
    run_string("R9", 8'hF3);
    check("R9", crc_o, 32'h0376_E6E7);
    run_string("R9", 8'h0B);
    check("R9", crc_o, 32'h0000_29B1);

    // disabled: bytes ignored
    run_string("R6", 8'h04);
    check("R6", crc_o, 32'hFFFF_FFFF);

    // restart with a byte in the same cycle: byte dropped
    cyc("R2", 1'b1, 8'h01, 1'b0, 1'b0, 8'h00);
    cyc("R5", 1'b0, 8'h00, 1'b0, 1'b1, 8'h31);
    cyc("R7", 1'b0, 8'h00, 1'b1, 1'b1, 8'h32);
    check("R7", crc_o, 32'hFFFF_FFFF);
    cyc("R10", 1'b0, 8'h00, 1'b0, 1'b0, 8'h77);
    check("R10", crc_o, 32'hFFFF_FFFF);
    // mode write with a byte in the same cycle
    cyc("R5", 1'b0, 8'h00, 1'b0, 1'b1, 8'hA5);
    cyc("R7", 1'b1, 8'h09, 1'b0, 1'b1, 8'h5A);
    check("R7", crc_o, 32'h0000_FFFF);

    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom_range(0, 99);
      logic we = (r < 4);
      logic rs = (r >= 4 && r < 7);
      logic v  = ($urandom_range(0, 3) != 0);
      logic [7:0] wd = 8'($urandom);
      logic [7:0] d  = 8'($urandom);
      string tag;
      if (we) wd[0] = ($urandom_range(0, 4) != 0);
      if (we)                    tag = "R2";
      else if (rs)               tag = "R7";
      else if (!v)               tag = "R10";
      else if (!m_cfg[0])        tag = "R6";
      else if (m_cfg[3:2] == 2)  tag = "R8";
      else                       tag = "R5";
      cyc(tag, we, wd, rs, v, d);
    end
    finish_run();
  end
endmodule